// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block generates the frequency tuning word of a direct digital synthesizer during a linear chirp, and it owns the phase accumulator that the word feeds. Configuration supplies four values: a first word, a last word, a step size and a dwell count. The block advances the word from the first value toward the last value by one step each time the dwell count expires. The sweep runs upward when the last word is not below the first word, and downward otherwise. A sweep is triggered by a pulse on the update strobe, or by any change of the profile-select input.

When the sweep reaches its last word, the block does one of two things, chosen by the no-dwell input:

- **Hold:** it keeps the last frequency (state `SW_HOLD`).
- **Park:** it forces the phase accumulator to zero (state `SW_PARK`).

It stays in either state until a new trigger arrives. With sweep enable low, the block sits in `SW_IDLE` and puts out the first word as a fixed single tone. The no-dwell input then has no effect.

The state machine has four states:

| State | Meaning |
|-------|---------|
| `SW_IDLE` | Disabled. The word follows the first word. |
| `SW_RAMP` | Stepping toward the last word. |
| `SW_HOLD` | Finished. The word is parked on the last word. |
| `SW_PARK` | Finished. The accumulator is held at zero. |

The transitions are:

| Transition | Condition |
|------------|-----------|
| *disable* | Any state to `SW_IDLE` whenever sweep enable is low. |
| *load* | Any state to `SW_RAMP` on a trigger while enabled. |
| *finish-hold* | `SW_RAMP` to `SW_HOLD` on the final step with no-dwell low. |
| *finish-park* | `SW_RAMP` to `SW_PARK` on the final step with no-dwell high. |

Top module: `lfsweep_top`

## Requirements
- R1: While the synchronous active-low reset is low, and after it rises, the block is in `SW_IDLE`. In that state `ftw_out` equals `cfg_start`, `acc_clr` is 0, `sweep_done` is 0 and `phase_out` is 0.
- R2: While `sweep_en` is 0, the following hold:
  - `ftw_out` follows `cfg_start` one cycle later.
  - `acc_clr` and `sweep_done` stay 0 whatever the value of `no_dwell`.
  - A trigger starts no sweep.
- R3: A trigger sampled at a clock edge while `sweep_en` is 1 loads the sweep at that edge. From the next cycle, `ftw_out` equals `cfg_start` and `sweep_done` and `acc_clr` are 0.
- R4: In `SW_RAMP`, the word changes by `cfg_delta` once every `cfg_rate`+1 cycles, the first change coming `cfg_rate`+1 cycles after the load. The change is an addition when `cfg_end` >= the loaded `cfg_start`, and a subtraction otherwise.
- R5: A step that would reach or pass `cfg_end` puts out exactly `cfg_end`, including when the addition wraps past the word width. `sweep_done` rises in that same cycle.
- R6: After a sweep completes with `no_dwell` = 0, `ftw_out` stays at `cfg_end`, `sweep_done` stays 1 and `acc_clr` stays 0.
- R7: After completion, changing configuration without a trigger starts no new sweep.
- R8: Each cycle in which `acc_clr` is 0, `phase_out` grows by `ftw_out` modulo 2^PHASE_W. In the cycle after `acc_clr` is 1, `phase_out` is 0.
- R9: A sweep that completes with `no_dwell` = 1 raises `acc_clr` in the same cycle as `sweep_done`. Both stay high until a trigger or a disable.
- R10: A trigger is either `io_update` high at a clock edge, or a `profile_sel` value that differs from the value captured one cycle earlier. The second form loads the sweep two edges after the new value is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | FTW_W | First tuning word of the sweep |
| cfg_end | input | FTW_W | Last tuning word of the sweep |
| cfg_delta | input | FTW_W | Step size per update |
| cfg_rate | input | RATE_W | Extra cycles between steps (dwell count) |
| sweep_en | input | 1 | Enables sweeping; when low, emits `cfg_start` |
| no_dwell | input | 1 | 1: clear the accumulator at completion; 0: hold the final word |
| io_update | input | 1 | Update strobe, triggers a sweep |
| profile_sel | input | PROF_W | Profile selection; a change triggers a sweep |
| ftw_out | output | FTW_W | Current tuning word |
| acc_clr | output | 1 | Phase accumulator clear |
| sweep_done | output | 1 | Sweep has reached `cfg_end` |
| phase_out | output | PHASE_W | Phase accumulator value |

## Verification
The results have fixed latencies after a stimulus:

- An update strobe shows its loaded word one cycle later.
- A profile change shows its loaded word two cycles later, because of the capture register that detects the change.
- Step k of a sweep is visible k·(`cfg_rate`+1) cycles after the load.
- The accumulator reads zero one cycle after `acc_clr` is first seen.

The driver stamps every expected word, done flag and clear flag with the exact bench cycle number at which it must appear. The monitor compares each item only at that cycle, and an item whose cycle has passed unmatched is reported as a failure. The hold, park and disable checks sample several cycles after the state has settled. They also compare two consecutive accumulator samples against the current word.

// File: rtl/lfsweep_pkg.sv
package lfsweep_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_RAMP = 2'd1,
        SW_HOLD = 2'd2,
        SW_PARK = 2'd3
    } sweep_state_t;

endpackage

// File: rtl/lfsweep_trigger.sv
module lfsweep_trigger #(
    parameter int PROF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_update,
    input  logic [PROF_W-1:0] profile_sel,
    output logic              start_o
);

    logic [PROF_W-1:0] prof_now_q;
    logic [PROF_W-1:0] prof_prev_q;
    logic              prof_changed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_now_q  <= '0;
            prof_prev_q <= '0;
        end else begin
            prof_now_q  <= profile_sel;
            prof_prev_q <= prof_now_q;
        end
    end

    assign prof_changed = (prof_now_q != prof_prev_q);
    assign start_o      = io_update | prof_changed;

endmodule

// File: rtl/lfsweep_step.sv
module lfsweep_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] delta_i,
    input  logic [W-1:0] target_i,
    input  logic         up_i,
    output logic [W-1:0] next_o,
    output logic         last_o
);

    logic [W:0]   sum_wide;
    logic [W-1:0] gap_down;

    always_comb begin
        sum_wide = {1'b0, cur_i} + {1'b0, delta_i};
        gap_down = cur_i - target_i;
        if (up_i) begin
            // Compare in W+1 bits so a wrapping addition still counts as reaching the target.
            last_o = (sum_wide >= {1'b0, target_i});
            next_o = last_o ? target_i : sum_wide[W-1:0];
        end else begin
            last_o = (gap_down <= delta_i);
            next_o = last_o ? target_i : (cur_i - delta_i);
        end
    end

endmodule

// File: rtl/lfsweep_fsm.sv
module lfsweep_fsm
    import lfsweep_pkg::*;
#(
    parameter int FTW_W  = 32,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sweep_en,
    input  logic              no_dwell,
    input  logic [FTW_W-1:0]  cfg_start,
    input  logic [FTW_W-1:0]  cfg_end,
    input  logic [FTW_W-1:0]  cfg_delta,
    input  logic [RATE_W-1:0] cfg_rate,
    output logic [FTW_W-1:0]  ftw_o,
    output logic              clr_o,
    output logic              done_o
);

    sweep_state_t      st_q, st_d;
    logic [FTW_W-1:0]  ftw_q, ftw_d;
    logic [RATE_W-1:0] cnt_q, cnt_d;
    logic              up_q, up_d;
    logic              done_q, clr_q;
    logic              go_idle, go_load;
    logic [FTW_W-1:0]  step_next;
    logic              step_last;

    lfsweep_step #(.W(FTW_W)) u_step (
        .cur_i    (ftw_q),
        .delta_i  (cfg_delta),
        .target_i (cfg_end),
        .up_i     (up_q),
        .next_o   (step_next),
        .last_o   (step_last)
    );

    // Next-state and datapath
    always_comb begin
        st_d    = st_q;
        ftw_d   = ftw_q;
        cnt_d   = cnt_q;
        up_d    = up_q;
        go_idle = !sweep_en;
        go_load = sweep_en && start_i;
        if (go_idle) begin
            st_d  = SW_IDLE;
            ftw_d = cfg_start;
        end else if (go_load) begin
            st_d  = SW_RAMP;
            ftw_d = cfg_start;
            cnt_d = cfg_rate;
            up_d  = (cfg_end >= cfg_start);
        end else begin
            unique case (st_q)
                SW_IDLE: begin
                    ftw_d = cfg_start;
                end
                SW_RAMP: begin
                    if (cnt_q == '0) begin
                        cnt_d = cfg_rate;
                        ftw_d = step_next;
                        if (step_last) begin
                            st_d = no_dwell ? SW_PARK : SW_HOLD;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                SW_HOLD: begin
                    st_d = SW_HOLD;
                end
                SW_PARK: begin
                    st_d = SW_PARK;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SW_IDLE;
            ftw_q <= cfg_start;
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            st_q  <= st_d;
            ftw_q <= ftw_d;
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    // Outputs, registered from the next state so they line up with the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            done_q <= (st_d == SW_HOLD) || (st_d == SW_PARK);
            clr_q  <= (st_d == SW_PARK);
        end
    end

    assign ftw_o  = ftw_q;
    assign done_o = done_q;
    assign clr_o  = clr_q;

    // R5
    end_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (ftw_q == $past(cfg_end)));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SW_HOLD && !start_i && sweep_en) |=> (ftw_q == $past(ftw_q)));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> (!clr_q && !done_q));

    // R9
    clr_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> done_q);

endmodule

// File: rtl/lfsweep_phase.sv
module lfsweep_phase #(
    parameter int FTW_W   = 32,
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FTW_W-1:0]   ftw_i,
    input  logic               clr_i,
    output logic [PHASE_W-1:0] acc_o
);

    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + PHASE_W'(ftw_i);
        end
    end

    assign acc_o = acc_q;

    // R8
    acc_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (acc_q == '0));

    // R8
    acc_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && $past(rst_n)) |=> (acc_q == $past(acc_q) + PHASE_W'($past(ftw_i))));

endmodule

// File: rtl/lfsweep_top.sv
module lfsweep_top #(
    parameter int FTW_W   = 32,
    parameter int RATE_W  = 8,
    parameter int PROF_W  = 2,
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FTW_W-1:0]   cfg_start,
    input  logic [FTW_W-1:0]   cfg_end,
    input  logic [FTW_W-1:0]   cfg_delta,
    input  logic [RATE_W-1:0]  cfg_rate,
    input  logic               sweep_en,
    input  logic               no_dwell,
    input  logic               io_update,
    input  logic [PROF_W-1:0]  profile_sel,
    output logic [FTW_W-1:0]   ftw_out,
    output logic               acc_clr,
    output logic               sweep_done,
    output logic [PHASE_W-1:0] phase_out
);

    logic start_evt;

    lfsweep_trigger #(.PROF_W(PROF_W)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_update   (io_update),
        .profile_sel (profile_sel),
        .start_o     (start_evt)
    );

    lfsweep_fsm #(.FTW_W(FTW_W), .RATE_W(RATE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_evt),
        .sweep_en  (sweep_en),
        .no_dwell  (no_dwell),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .cfg_delta (cfg_delta),
        .cfg_rate  (cfg_rate),
        .ftw_o     (ftw_out),
        .clr_o     (acc_clr),
        .done_o    (sweep_done)
    );

    lfsweep_phase #(.FTW_W(FTW_W), .PHASE_W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ftw_i (ftw_out),
        .clr_i (acc_clr),
        .acc_o (phase_out)
    );

endmodule

// File: tb/lfsweep_top_test.sv
`timescale 1ns/1ps
module lfsweep_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start = '0, cfg_end = '0, cfg_delta = '0;
    logic [7:0]  cfg_rate = '0;
    logic        sweep_en = 1'b0, no_dwell = 1'b0, io_update = 1'b0;
    logic [1:0]  profile_sel = '0;
    logic [31:0] ftw_out;
    logic        acc_clr, sweep_done;
    logic [31:0] phase_out;

    always #2.5 clk = ~clk;

    lfsweep_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_delta(cfg_delta), .cfg_rate(cfg_rate), .sweep_en(sweep_en),
        .no_dwell(no_dwell), .io_update(io_update), .profile_sel(profile_sel),
        .ftw_out(ftw_out), .acc_clr(acc_clr), .sweep_done(sweep_done),
        .phase_out(phase_out)
    );

    typedef struct {
        int          when;
        logic [31:0] ftw;
        logic        done;
        logic        clr;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare each expected item in its own cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            if (sb[0].when == cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk({ftw_out, sweep_done, acc_clr} == {e.ftw, e.done, e.clr}, e.req,
                    {30'd0, ftw_out, sweep_done, acc_clr}, {30'd0, e.ftw, e.done, e.clr});
            end else if (sb[0].when < cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(1'b0, {e.req, " missed"}, 64'(sb.size()), 64'(e.when));
            end
        end
    end

    // Driver: apply a trigger and push the expected sweep trajectory
    task automatic run_sweep(input bit via_prof, input logic [31:0] s, input logic [31:0] e,
                             input logic [31:0] d, input logic [7:0] rate, input bit nd);
        int          lat;
        int          t;
        int          k;
        logic [31:0] cur;
        logic [32:0] sum;
        bit          up;
        bit          last;
        logic [31:0] nxt;
        exp_t        item;
        cfg_start = s; cfg_end = e; cfg_delta = d; cfg_rate = rate; no_dwell = nd;
        if (via_prof) begin
            profile_sel = profile_sel + 2'd1;
            lat = 2;                                  // R10
        end else begin
            io_update = 1'b1;
            lat = 1;                                  // R3
        end
        t = cyc;
        item.when = t + lat; item.ftw = s; item.done = 1'b0; item.clr = 1'b0;
        item.req = via_prof ? "R10 load" : "R3 load";
        sb.push_back(item);
        up = (e >= s);
        cur = s;
        k = 0;
        last = 1'b0;
        while (!last) begin
            k++;
            if (up) begin
                sum = {1'b0, cur} + {1'b0, d};
                last = (sum >= {1'b0, e});
                nxt = last ? e : sum[31:0];
            end else begin
                last = ((cur - e) <= d);
                nxt = last ? e : cur - d;
            end
            item.when = t + lat + k * (int'(rate) + 1);
            item.ftw  = nxt;
            item.done = last;
            item.clr  = last && nd;
            item.req  = last ? (nd ? "R5/R9 final" : "R5 final") : "R4 step";
            sb.push_back(item);
            cur = nxt;
        end
        if (!via_prof) begin
            @(negedge clk);
            io_update = 1'b0;
        end
    endtask

    task automatic wait_sb();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic phase_step_chk(input string req);
        logic [31:0] p0;
        logic [31:0] w;
        @(negedge clk);
        p0 = phase_out;
        w = ftw_out;
        @(negedge clk);
        chk(phase_out == p0 + w, req, 64'(phase_out), 64'(p0 + w));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 64'(cyc), 64'd0);
        finish_run();
    end

    initial begin
        // R1: reset state
        cfg_start = 32'h0000_1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ftw_out == 32'h1234, "R1 ftw in reset", 64'(ftw_out), 64'h1234);
        chk({acc_clr, sweep_done} == 2'b00 && phase_out == 0, "R1 flags in reset",
            {acc_clr, sweep_done, phase_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ftw_out == 32'h1234 && !sweep_done && !acc_clr, "R1 after release",
            64'(ftw_out), 64'h1234);

        // R3 R4 R5 upward sweep, hold at end
        sweep_en = 1'b1;
        @(negedge clk);
        run_sweep(1'b0, 32'd100, 32'd160, 32'd16, 8'd2, 1'b0);
        wait_sb();
        repeat (5) @(negedge clk);
        chk(ftw_out == 160 && sweep_done && !acc_clr, "R6 hold",
            {ftw_out, sweep_done, acc_clr}, {32'd160, 2'b10});
        phase_step_chk("R8 add in hold");

        // R7: configuration writes alone do not restart
        cfg_start = 32'd9;
        cfg_end = 32'd4000;
        repeat (20) @(negedge clk);
        chk(ftw_out == 160 && sweep_done, "R7 no restart", 64'(ftw_out), 64'd160);

        // R4 descending, R9 no-dwell park
        run_sweep(1'b0, 32'd500, 32'd470, 32'd10, 8'd0, 1'b1);
        wait_sb();
        repeat (10) @(negedge clk);
        chk(acc_clr && sweep_done && phase_out == 0, "R9 parked",
            {acc_clr, sweep_done, phase_out}, {2'b11, 32'd0});
        chk(phase_out == 0, "R8 cleared accumulator", 64'(phase_out), 64'd0);

        // R10 profile change leaves park; R5 wrapping addition saturates
        run_sweep(1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h20, 8'd1, 1'b0);
        wait_sb();
        @(negedge clk);
        chk(!acc_clr && sweep_done, "R9 released by trigger", {acc_clr, sweep_done}, 64'b01);

        // R10 multi-step sweep via profile
        run_sweep(1'b1, 32'd1000, 32'd1100, 32'd40, 8'd3, 1'b0);
        wait_sb();

        // R5 start equals end
        run_sweep(1'b0, 32'd50, 32'd50, 32'd7, 8'd1, 1'b1);
        wait_sb();

        // R2 disabled: no_dwell ignored, triggers do nothing
        sweep_en = 1'b0;
        cfg_start = 32'd777;
        @(negedge clk);
        @(negedge clk);
        chk(ftw_out == 777 && !acc_clr && !sweep_done, "R2 disabled",
            {ftw_out, acc_clr, sweep_done}, {32'd777, 2'b00});
        io_update = 1'b1;
        @(negedge clk);
        io_update = 1'b0;
        repeat (8) @(negedge clk);
        chk(ftw_out == 777 && !acc_clr && !sweep_done, "R2 trigger ignored",
            {ftw_out, acc_clr, sweep_done}, {32'd777, 2'b00});
        phase_step_chk("R2 R8 accumulating while disabled");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule